// File: doc/BRIEF.md
# Asynchronous Static Memory Access Controller

This controller sits between a clocked host and an external asynchronous static memory that holds 32K bytes. The host hands over one request at a time through a valid/ready port. Each request carries an address, a write flag and a write byte. The controller turns the request into a read or write cycle on the memory pins, using active-low select, output-enable and write-enable strobes. It then answers with a single-cycle acknowledge. For a read, the acknowledge carries the byte that was fetched.

The length of every phase is a whole number of clock cycles. Each count is the ceiling of a nanosecond requirement divided by the clock-period parameter, and never less than one. A read keeps select and output enable low for the longer of the address access time and the output-enable access time. The byte is captured on the last edge of that window. The controller then idles with output enable high for long enough that the memory releases the shared bus.

A write is the overlap of select low and write enable low. The controller drives the data lines from the start of that overlap. It raises both strobes together and keeps driving the byte for a hold phase afterwards. The hold phase is long enough that the whole write cycle meets its minimum length.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is applied and after it is released, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A read request (`req_write`=0) drives `mem_ce_n`=0 and `mem_oe_n`=0 with `mem_we_n`=1 for exactly max(ceil(70/P), ceil(35/P)) clock cycles, where P is the clock period in ns. The byte on `mem_dq_i` at the last edge of that window is returned on `rsp_rdata` in the cycle where `rsp_valid`=1.
- R3: A write request (`req_write`=1) drives `mem_ce_n`=0 and `mem_we_n`=0 together, with `mem_oe_n`=1, for exactly max(ceil(50/P), ceil(60/P), ceil(30/P)) cycles. During the whole of that pulse, `mem_dq_oe`=1 and `mem_dq_o` carries the request byte.
- R4: After a write pulse ends, `mem_dq_oe` stays 1 with the same byte for max(1, ceil(70/P) − pulse cycles) cycles. The write pulse plus this hold phase lasts at least 70 ns. The bus is then released.
- R5: `mem_addr` holds the request address, unchanged, throughout every read window and every write pulse.
- R6: `mem_dq_oe` is 1 only while `mem_oe_n` is 1, and `mem_oe_n` and `mem_we_n` are never both 0.
- R7: After a read, `mem_oe_n` stays 1 for at least ceil(25/P) cycles (at least 25 ns) before the next access lowers `mem_ce_n`.
- R8: `rsp_valid` is a one-cycle pulse, given once per accepted request in request order. `req_ready` is 0 from acceptance until the access and its recovery are complete. A request presented while `req_ready`=0 has no effect on the memory.
- R9: With the default period of 5 ns, the phase counts are 14 cycles of read access, 5 cycles of read recovery, 12 cycles of write pulse and 2 cycles of write hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host presents a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Memory byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | One-cycle acknowledge |
| rsp_rdata | output | 8 | Byte fetched by the last read |
| mem_addr | output | 15 | Address lines to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Byte driven onto the shared data lines |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 8 | Resolved data lines seen by the controller |

## Verification
The memory model in the bench returns a garbage byte until 70 ns have elapsed since the read window opened. A read window that is even one cycle short therefore returns the wrong byte, whereas a correct window returns the byte last written. Writes use complementary bytes (A5/5A, 00/FF) and a walking-one address pattern across all 15 address bits, so stuck or swapped address and data lines show up on read-back. The bench also issues back-to-back read-after-write and write-after-read pairs, which exercise the bus turnaround and recovery gaps. A write presented while the controller is busy must leave the target location unchanged, which separates a request that is ignored from one that is latched.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_REC,
    ST_WR_PULSE,
    ST_WR_HOLD
  } ctl_state_e;

  // ceiling of t_ns / clk_ns, at least one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned n;
    n = (t_ns + clk_ns - 1) / clk_ns;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_data_io.sv
module sram_data_io #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drive_start,
  input  logic          drive_stop,
  input  logic [DW-1:0] wdata,
  input  logic          capture,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_o  <= '0;
      dq_oe <= 1'b0;
    end else if (drive_start) begin
      dq_o  <= wdata;
      dq_oe <= 1'b1;
    end else if (drive_stop) begin
      dq_oe <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (capture)
      rdata <= dq_i;
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CLK_NS   = 5,
  parameter int unsigned T_AA_NS  = 70,  // address to data valid
  parameter int unsigned T_DOE_NS = 35,  // output enable to data valid
  parameter int unsigned T_HZ_NS  = 25,  // output release after output enable rises
  parameter int unsigned T_PWE_NS = 50,  // write strobe width
  parameter int unsigned T_SCE_NS = 60,  // select low to end of write
  parameter int unsigned T_AW_NS  = 60,  // address valid to end of write
  parameter int unsigned T_SD_NS  = 30,  // data setup to end of write
  parameter int unsigned T_WC_NS  = 70   // write cycle
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned P_RD = umax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int unsigned P_HZ = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned P_WP = umax(umax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SCE_NS, CLK_NS)),
                                      umax(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)));
  localparam int unsigned WC_CYC = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned P_WH = (WC_CYC > P_WP + 1) ? (WC_CYC - P_WP) : 1;
  localparam int unsigned P_MAX = umax(umax(P_RD, P_HZ), umax(P_WP, P_WH));
  localparam int unsigned CW = $clog2(P_MAX + 1);

  ctl_state_e state;

  // named events for the checker
  logic          accept;
  logic          phase_done;
  logic          rd_capture;
  logic          wr_strobe_end;
  logic          wr_release;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;

  assign req_ready     = (state == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign phase_done    = tmr_expired && (state != ST_IDLE);
  assign rd_capture    = (state == ST_RD_ACC)   && phase_done;
  assign wr_strobe_end = (state == ST_WR_PULSE) && phase_done;
  assign wr_release    = (state == ST_WR_HOLD)  && phase_done;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = req_write ? CW'(P_WP - 1) : CW'(P_RD - 1);
    end else if (rd_capture) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(P_HZ - 1);
    end else if (wr_strobe_end) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(P_WH - 1);
    end
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_data_io #(.DW(DATA_W)) u_io (
    .clk         (clk),
    .rst_n       (rst_n),
    .drive_start (accept && req_write),
    .drive_stop  (wr_release),
    .wdata       (req_wdata),
    .capture     (rd_capture),
    .dq_i        (mem_dq_i),
    .dq_o        (mem_dq_o),
    .dq_oe       (mem_dq_oe),
    .rdata       (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          mem_addr <= req_addr;
          mem_ce_n <= 1'b0;
          if (req_write) begin
            mem_we_n <= 1'b0;
            state    <= ST_WR_PULSE;
          end else begin
            mem_oe_n <= 1'b0;
            state    <= ST_RD_ACC;
          end
        end
        ST_RD_ACC: if (rd_capture) begin
          mem_ce_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          rsp_valid <= 1'b1;
          state     <= ST_RD_REC;
        end
        ST_RD_REC: if (phase_done) state <= ST_IDLE;
        ST_WR_PULSE: if (wr_strobe_end) begin
          mem_we_n <= 1'b1;
          mem_ce_n <= 1'b1;
          state    <= ST_WR_HOLD;
        end
        ST_WR_HOLD: if (wr_release) begin
          rsp_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned CLK_NS   = 5,
  parameter int unsigned T_AA_NS  = 70,
  parameter int unsigned T_HZ_NS  = 25,
  parameter int unsigned T_SCE_NS = 60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  logic [15:0] we_lo_cnt;
  logic [15:0] oe_lo_cnt;
  logic [15:0] oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
      oe_hi_cnt <= 16'hFFFF;
    end else begin
      we_lo_cnt <= mem_we_n ? '0 : we_lo_cnt + 1'b1;
      oe_lo_cnt <= mem_oe_n ? '0 : oe_lo_cnt + 1'b1;
      if (!mem_oe_n)
        oe_hi_cnt <= '0;
      else if (oe_hi_cnt != 16'hFFFF)
        oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe)); // R1

  AST_RD_ACCESS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (32'(oe_lo_cnt) * CLK_NS >= T_AA_NS)); // R2

  AST_WE_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n); // R3

  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (32'(we_lo_cnt) * CLK_NS >= T_SCE_NS)); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |=> $stable(mem_addr)); // R5

  AST_BUS_ONLY_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R6

  AST_NO_OE_WE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R6

  AST_RD_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (32'(oe_hi_cnt) * CLK_NS >= T_HZ_NS)); // R7

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .CLK_NS   (CLK_NS),
  .T_AA_NS  (T_AA_NS),
  .T_HZ_NS  (T_HZ_NS),
  .T_SCE_NS (T_SCE_NS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/1ps
module sram_async_ctrl_test;

  localparam int CLK_P = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_o, mem_dq_i;

  logic        model_drv = 1'b0;
  logic [7:0]  model_dq = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // resolved bus: controller wins, contention is flagged by the model
  assign mem_dq_i = mem_dq_oe ? mem_dq_o : (model_drv ? model_dq : 8'h00);

  sram_async_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // smallest n with n*CLK_P >= t, at least 1
  function automatic int cyc_of(input int t);
    int n = 1;
    while (n * CLK_P < t) n++;
    return n;
  endfunction

  int exp_rd, exp_wp, exp_wh, exp_hz;
  initial begin
    exp_rd = (cyc_of(70) > cyc_of(35)) ? cyc_of(70) : cyc_of(35);
    exp_wp = cyc_of(60);
    if (cyc_of(50) > exp_wp) exp_wp = cyc_of(50);
    exp_wh = (cyc_of(70) - exp_wp > 1) ? cyc_of(70) - exp_wp : 1;
    exp_hz = cyc_of(25);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // ---------------- memory model ----------------
  logic [7:0] sram[int];
  logic [7:0] shadow[int];
  bit   rd_act_q = 0, wr_act_q = 0, in_hold = 0, after_rd = 0;
  int   lo_rd = 0, lo_wr = 0, hold_cnt = 0;
  real  t_sel = 0.0, t_oe_rise = 0.0;
  logic [14:0] act_addr = '0;
  logic [7:0]  wr_data_q = '0;

  always @(negedge clk) if (rst_n) begin
    bit rd_act, wr_act;
    rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;
    wr_act = !mem_ce_n && !mem_we_n;
    if (!mem_oe_n && !mem_we_n) check(0, "R6 oe/we overlap", 1, 0);
    if (model_drv && mem_dq_oe) check(0, "R6 bus contention", 1, 0);
    if (!mem_ce_n && !rd_act_q && !wr_act_q && after_rd) begin
      check(($realtime - t_oe_rise) >= 25.0, "R7 recovery ns", int'($realtime - t_oe_rise), 25);
      after_rd = 0;
    end
    // read side
    if (rd_act) begin
      if (!rd_act_q) begin t_sel = $realtime; act_addr = mem_addr; lo_rd = 0; end
      lo_rd++;
      if (mem_addr != act_addr) check(0, "R5 read addr moved", mem_addr, act_addr);
      model_drv = 1'b1;
      if ($realtime - t_sel + CLK_P >= 70.0)
        model_dq = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 8'h00;
      else
        model_dq = 8'hEE;
    end else begin
      model_drv = 1'b0;
    end
    if (rd_act_q && !rd_act) begin
      check(lo_rd == exp_rd, "R2/R9 read window cycles", lo_rd, exp_rd);
      t_oe_rise = $realtime;
      after_rd = 1;
    end
    // write side
    if (in_hold) begin
      if (mem_dq_oe) begin
        hold_cnt++;
        if (mem_dq_o != wr_data_q) check(0, "R4 hold data", mem_dq_o, wr_data_q);
      end else begin
        in_hold = 0;
        check(hold_cnt == exp_wh, "R4/R9 hold cycles", hold_cnt, exp_wh);
        check((lo_wr + hold_cnt) * CLK_P >= 70, "R4 write cycle ns", (lo_wr + hold_cnt) * CLK_P, 70);
      end
    end
    if (wr_act) begin
      if (!wr_act_q) begin act_addr = mem_addr; lo_wr = 0; end
      lo_wr++;
      if (!mem_dq_oe) check(0, "R3 data not driven", 0, 1);
      if (mem_addr != act_addr) check(0, "R5 write addr moved", mem_addr, act_addr);
      wr_data_q = mem_dq_o;
    end
    if (wr_act_q && !wr_act) begin
      sram[int'(act_addr)] = wr_data_q;
      check(lo_wr == exp_wp, "R3/R9 write pulse cycles", lo_wr, exp_wp);
      in_hold = 1;
      hold_cnt = 0;
      if (mem_dq_oe) hold_cnt++;
    end
    rd_act_q = rd_act;
    wr_act_q = wr_act;
  end

  // ---------------- scoreboard ----------------
  typedef struct packed { logic wr; logic [7:0] data; } exp_t;
  exp_t exp_q[$];
  bit prev_rsp = 0;

  always @(negedge clk) if (rst_n) begin
    if (prev_rsp && rsp_valid) check(0, "R8 ack longer than one cycle", 1, 0);
    if (rsp_valid) begin
      if (exp_q.size() == 0) check(0, "R8 unexpected ack", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        if (!e.wr) check(rsp_rdata == e.data, "R2 read data", rsp_rdata, e.data);
        else checks++;
      end
    end
    prev_rsp = rsp_valid;
  end

  task automatic do_req(input bit wr, input logic [14:0] a, input logic [7:0] d);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    e.wr = wr;
    if (wr) begin shadow[int'(a)] = d; e.data = d; end
    else e.data = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    check(!mem_dq_oe && !rsp_valid, "R1 bus/ack in reset", {mem_dq_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && mem_ce_n && !mem_dq_oe, "R1 after reset", {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);

    do_req(1, 15'h0000, 8'hA5);
    do_req(1, 15'h7FFF, 8'h5A);
    do_req(1, 15'h0001, 8'hFF);
    do_req(1, 15'h0002, 8'h00);
    do_req(0, 15'h0000, 8'h00);
    do_req(0, 15'h7FFF, 8'h00);
    do_req(0, 15'h0001, 8'h00);
    do_req(0, 15'h0002, 8'h00);
    do_req(0, 15'h1234, 8'h00);      // never written
    for (int i = 0; i < 15; i++) do_req(1, 15'(1 << i), 8'(8'h30 + i));
    for (int i = 0; i < 15; i++) do_req(0, 15'(1 << i), 8'h00);
    // back-to-back turnarounds
    do_req(1, 15'h0055, 8'h3C);
    do_req(0, 15'h0055, 8'h00);
    do_req(1, 15'h0055, 8'hC3);
    do_req(0, 15'h0055, 8'h00);

    // R8: a write offered while busy must be ignored
    do_req(0, 15'h0000, 8'h00);
    check(!req_ready, "R8 busy not ready", req_ready, 0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0000; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 1'b0;
    do_req(0, 15'h0000, 8'h00);      // still A5

    while (exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * CLK_P);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

endmodule